// File: doc/BRIEF.md
# DMA Packet Interrupt Coalescer

This block sits beside one scatter-gather DMA channel and decides when the channel interrupts the processor. The DMA engine sends it a pulse for each finished packet. The block keeps a count of the packets that software has not yet handled. It flags a threshold event when that count reaches a programmed level. It flags a wait-bound event when a millisecond timer runs out first. It also records end-of-descriptor-list events and bus errors reported by the engine.

Software sees the block through a small word-wide register port. It programs the threshold, the wait bound and the interrupt enables. It reads the pending packet count and retires packets one at a time by writing to the count register. It acknowledges status bits by writing ones to toggle them. The threshold and the wait bound can only be written while the channel is stopped. A one-cycle `tick_ms_i` pulse supplies the millisecond time base.

Top module: `dma_coal_irq`

## Requirements
- R1: The threshold register at address 0 holds 8 bits (read back zero-extended). A threshold of 0 disables threshold events.
- R2: The wait-bound register at address 1 holds 10 bits, counted in `tick_ms_i` pulses. A value of 0 disables wait-bound events.
- R3: Writes to address 0 or 1 are ignored while `chan_run_i` is high.
- R4: Each `pkt_done_i` pulse adds one to the pending count, which saturates at 255. The count is read at address 2, and any write to address 2 removes one packet.
- R5: A removal while the count is 0 leaves it at 0. A packet and a removal in the same cycle leave the count unchanged.
- R6: Status bit 0 becomes set on the edge after any cycle in which the threshold is nonzero and the count is at or above it. Clearing the bit while this holds has no lasting effect.
- R7: The wait timer loads the wait bound on every packet and counts ticks only while the count is nonzero. Status bit 1 becomes set on the tick that completes the bound since the last packet, unless the count is at or above a nonzero threshold.
- R8: A `list_end_i` pulse sets status bit 2, and a `bus_err_i` pulse sets status bit 3.
- R9: Writing the status register at address 3 toggles each of bits 3..0 that is written as 1. A set event in the same cycle takes precedence over the toggle.
- R10: The enable register at address 4 holds 4 bits. `irq_o` is high exactly when some status bit and its enable bit are both 1.
- R11: Reset clears the threshold, wait bound, count, status and enables. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chan_run_i | input | 1 | Channel started; locks threshold and wait bound |
| pkt_done_i | input | 1 | One packet completed by the DMA engine |
| list_end_i | input | 1 | End of descriptor list reached |
| bus_err_i | input | 1 | DMA bus error or timeout |
| tick_ms_i | input | 1 | Millisecond time-base pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench clears the threshold bit while the count is still at the threshold. A design that treats the bit as an edge event would drop it for good, and the bench expects it to stay set. The bench also writes a 1 to a status bit that is already clear. A design that clears the bit instead of toggling it would leave it at 0, where the bench expects 1. It removes packets at a count of zero and issues a packet and a removal in the same cycle. An off-by-one counter would wrap to 255 or drift by one. It gives the wait timer exactly one tick fewer than the bound, then exactly the bound, and restarts it with a packet in mid-count. A timer that fires early or late, or that does not reload, disagrees with the model in a specific cycle. It also writes the threshold and bound while the channel runs, runs the count into saturation, and checks that a zero threshold and a zero bound both suppress their events.

// File: rtl/dma_coal_pkg.sv
package dma_coal_pkg;
  localparam int ADDR_W  = 3;
  localparam int NUM_STS = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_THR = 3'd0,
    REG_WB  = 3'd1,
    REG_CNT = 3'd2,
    REG_STS = 3'd3,
    REG_EN  = 3'd4
  } reg_sel_e;

  localparam int ST_THR = 0;
  localparam int ST_WB  = 1;
  localparam int ST_END = 2;
  localparam int ST_ERR = 3;
endpackage

// File: rtl/coal_pkt_counter.sv
module coal_pkt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign count_o = cnt_q;

  p_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && cnt_q == '0) |=> (cnt_q == '0));
  p_pair_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && inc_i) |=> $stable(cnt_q));
  p_ceiling_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/coal_wait_timer.sv
module coal_wait_timer #(
  parameter int WB_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [WB_W-1:0] bound_i,
  input  logic            active_i,
  input  logic            pkt_i,
  input  logic            tick_i,
  output logic            expire_o
);
  logic [WB_W-1:0] tmr_q;
  logic            running;

  assign running  = active_i && (bound_i != '0);
  assign expire_o = running && tick_i && !pkt_i && (tmr_q == WB_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_q <= '0;
    else if (pkt_i || !running) tmr_q <= bound_i;
    else if (tick_i && tmr_q != '0) tmr_q <= tmr_q - 1'b1;
  end

  p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_i |=> (tmr_q == $past(bound_i)));
  p_expire_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> (active_i && bound_i != '0 && tick_i));
endmodule

// File: rtl/coal_status.sv
module coal_status #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] tog_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q[i] <= 1'b0;
      else         sts_q[i] <= (sts_q[i] ^ tog_i[i]) | set_i[i];
    end

    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> sts_q[i]);
    p_toggle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tog_i[i] && !set_i[i]) |=> (sts_q[i] != $past(sts_q[i])));
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/dma_coal_irq.sv
module dma_coal_irq
  import dma_coal_pkg::*;
#(
  parameter int THR_W  = 8,
  parameter int WB_W   = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chan_run_i,
  input  logic              pkt_done_i,
  input  logic              list_end_i,
  input  logic              bus_err_i,
  input  logic              tick_ms_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = THR_W;

  logic [THR_W-1:0]   thr_q;
  logic [WB_W-1:0]    wb_q;
  logic [NUM_STS-1:0] en_q;
  logic [CNT_W-1:0]   count;
  logic [NUM_STS-1:0] sts, sts_set, sts_tog;
  logic               thr_hit, wb_expire, dec_cmd, cfg_open;

  assign cfg_open = reg_we_i && !chan_run_i;
  assign dec_cmd  = reg_we_i && (reg_addr_i == REG_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= '0;
      wb_q  <= '0;
      en_q  <= '0;
    end else begin
      if (cfg_open && reg_addr_i == REG_THR) thr_q <= reg_wdata_i[THR_W-1:0];
      if (cfg_open && reg_addr_i == REG_WB)  wb_q  <= reg_wdata_i[WB_W-1:0];
      if (reg_we_i && reg_addr_i == REG_EN)  en_q  <= reg_wdata_i[NUM_STS-1:0];
    end
  end

  coal_pkt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (pkt_done_i),
    .dec_i  (dec_cmd),
    .count_o(count)
  );

  assign thr_hit = (thr_q != '0) && (count >= thr_q);

  coal_wait_timer #(.WB_W(WB_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bound_i (wb_q),
    .active_i(count != '0),
    .pkt_i   (pkt_done_i),
    .tick_i  (tick_ms_i),
    .expire_o(wb_expire)
  );

  always_comb begin
    sts_set         = '0;
    sts_set[ST_THR] = thr_hit;
    sts_set[ST_WB]  = wb_expire && !thr_hit;
    sts_set[ST_END] = list_end_i;
    sts_set[ST_ERR] = bus_err_i;
  end

  assign sts_tog = (reg_we_i && reg_addr_i == REG_STS) ? reg_wdata_i[NUM_STS-1:0] : '0;

  coal_status #(.N(NUM_STS)) u_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sts_set),
    .tog_i (sts_tog),
    .sts_o (sts)
  );

  always_comb begin
    case (reg_addr_i)
      REG_THR: reg_rdata_o = DATA_W'(thr_q);
      REG_WB:  reg_rdata_o = DATA_W'(wb_q);
      REG_CNT: reg_rdata_o = DATA_W'(count);
      REG_STS: reg_rdata_o = DATA_W'(sts);
      REG_EN:  reg_rdata_o = DATA_W'(en_q);
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(sts & en_q);

  p_thr_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_run_i && reg_we_i && reg_addr_i == REG_THR) |=> $stable(thr_q));
  p_wb_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_run_i && reg_we_i && reg_addr_i == REG_WB) |=> $stable(wb_q));
  p_thr_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_hit |=> sts[ST_THR]);
  p_wb_needs_pkt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_expire |-> (count != '0));
endmodule

// File: tb/dma_coal_irq_test.sv
module dma_coal_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 0, pkt = 0, lend = 0, berr = 0, tick = 0, we = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wd = 0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_thr = 0, m_wb = 0, m_cnt = 0, m_sts = 0, m_en = 0, m_tmr = 0;

  always #10 clk = ~clk;

  dma_coal_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .chan_run_i(run), .pkt_done_i(pkt),
    .list_end_i(lend), .bus_err_i(berr), .tick_ms_i(tick), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_thr = 0; m_wb = 0; m_cnt = 0; m_sts = 0; m_en = 0; m_tmr = 0;
    end else begin
      bit hit, act, exp_ev, dec;
      int setv;
      hit    = (m_thr != 0) && (m_cnt >= m_thr);
      act    = (m_cnt != 0) && (m_wb != 0);
      exp_ev = act && tick && !pkt && (m_tmr == 1);
      dec    = we && addr == 2;
      if (pkt || !act) m_tmr = m_wb;
      else if (tick && m_tmr > 0) m_tmr = m_tmr - 1;
      if (pkt && !dec && m_cnt < 255) m_cnt = m_cnt + 1;
      else if (dec && !pkt && m_cnt > 0) m_cnt = m_cnt - 1;
      setv = (hit ? 1 : 0) | ((exp_ev && !hit) ? 2 : 0) | (lend ? 4 : 0) | (berr ? 8 : 0);
      m_sts = (m_sts ^ ((we && addr == 3) ? int'(wd[3:0]) : 0)) | setv;
      if (we && !run && addr == 0) m_thr = int'(wd[7:0]);
      if (we && !run && addr == 1) m_wb = int'(wd[9:0]);
      if (we && addr == 4) m_en = int'(wd[3:0]);
    end
  end

  function automatic int model_rd(input int a);
    case (a)
      0: return m_thr;
      1: return m_wb;
      2: return m_cnt;
      3: return m_sts;
      4: return m_en;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R10 irq per-cycle", int'(irq), ((m_sts & m_en) != 0) ? 1 : 0);
      chk("R11 rdata per-cycle", int'(rdata), model_rd(int'(addr)));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input int a, input int d);
    we = 1; addr = 3'(a); wd = 32'(d); @(negedge clk); we = 0;
  endtask
  task automatic rd(input int a, output int v);
    addr = 3'(a); #1; v = int'(rdata);
  endtask
  task automatic pkts(input int n);
    repeat (n) begin pkt = 1; @(negedge clk); pkt = 0; end
  endtask
  task automatic ticks(input int n);
    repeat (n) begin tick = 1; @(negedge clk); tick = 0; @(negedge clk); end
  endtask
  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int v;
    cyc(2); rst_n = 1; cyc(1);
    // R11 reset state
    for (int a = 0; a < 8; a++) begin rd(a, v); chk("R11 reset read", v, 0); end
    chk("R11 reset irq", int'(irq), 0);

    // R1 / R3 config while stopped and while running
    wr(0, 32'h1_03); rd(0, v); chk("R1 thr 8-bit", v, 3);
    wr(1, 32'hFC04); rd(1, v); chk("R2 wb 10-bit", v, 32'h004);
    run = 1;
    wr(0, 7); rd(0, v); chk("R3 thr locked", v, 3);
    wr(1, 9); rd(1, v); chk("R3 wb locked", v, 4);

    // R4 / R6 threshold and re-set
    pkts(2); cyc(1); rd(3, v); chk("R6 below thr", v & 1, 0);
    pkts(1); rd(2, v); chk("R4 count", v, 3);
    cyc(1); rd(3, v); chk("R6 thr reached", v & 1, 1);
    wr(4, 1); #1; chk("R10 irq enabled", int'(irq), 1);
    wr(3, 1); rd(3, v); chk("R6 clear at thr re-sets", v & 1, 1);
    wr(2, 0); rd(2, v); chk("R4 decrement", v, 2);
    wr(3, 1); rd(3, v); chk("R9 toggle clear", v & 1, 0);
    #1; chk("R10 irq low", int'(irq), 0);

    // R9 toggle on a clear bit sets it; R8 event bits
    wr(3, 4); rd(3, v); chk("R9 toggle sets", v, 4);
    wr(3, 4); rd(3, v); chk("R9 toggle back", v, 0);
    lend = 1; cyc(1); lend = 0; rd(3, v); chk("R8 list end", v, 4);
    berr = 1; cyc(1); berr = 0; rd(3, v); chk("R8 bus error", v, 12);
    lend = 1; we = 1; addr = 3; wd = 4; cyc(1); lend = 0; we = 0;
    rd(3, v); chk("R9 set beats toggle", v, 12);
    wr(3, 12);

    // R5 floor and simultaneous
    wr(2, 0); wr(2, 0); wr(2, 0); rd(2, v); chk("R5 floor at 0", v, 0);
    pkt = 1; we = 1; addr = 2; cyc(1); pkt = 0; we = 0;
    rd(2, v); chk("R5 pair hold", v, 0);

    // R7 wait bound with thr above count
    run = 0; wr(0, 10); wr(1, 4); run = 1; wr(3, int'(rdata[3:0]));
    rd(3, v); wr(3, v);
    pkts(1); ticks(3); rd(3, v); chk("R7 not yet", (v >> 1) & 1, 0);
    ticks(1); rd(3, v); chk("R7 expired", (v >> 1) & 1, 1);
    wr(3, 2);
    pkts(1); ticks(2); pkts(1); ticks(3); rd(3, v); chk("R7 restart", (v >> 1) & 1, 0);
    ticks(1); rd(3, v); chk("R7 after restart", (v >> 1) & 1, 1);
    wr(3, 2);
    rd(2, v); repeat (v) wr(2, 0); rd(2, v); chk("R5 drained", v, 0);
    ticks(6); rd(3, v); chk("R7 idle at zero count", (v >> 1) & 1, 0);

    // R2 zero bound disables, R1 zero threshold disables
    run = 0; wr(1, 0); wr(0, 0); run = 1;
    pkts(5); ticks(8); rd(3, v); chk("R2/R1 disabled", v & 3, 0);

    // R4 saturation
    pkts(255); rd(2, v); chk("R4 saturate", v, 255);
    wr(2, 0); rd(2, v); chk("R4 dec from max", v, 254);

    cyc(2);
    finish_run();
  end
endmodule